// File: doc/BRIEF.md
# Pin-Change Interrupt Detector

This block watches a bank of already filtered input pins and turns selected activity on them into interrupt requests. Every pin has its own detector. In its default mode a pin reports any change of state. When the extended mode is switched on for a pin, it reports only one edge, or it reports a level that is held. The edge or level choice and the polarity are made per pin through their own configuration registers.

Each detected event sets a per-pin pending bit. Pending bits are kept in a status register, and reading that register clears them. A separate mask chooses which pending bits drive the single combined interrupt line. Software sets and clears the mask, the mode bits, the edge/level choice and the polarity through pairs of write-one strobe addresses, so one pin can change without a read-modify-write. Each of these registers can also be read back.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the mask, mode, kind and polarity registers read 0 (so every pin is in any-edge mode, kind edge, polarity falling/low), the status reads 0 and `irq_o` is low.
- R2: A write to address 0x0 sets the mask bits where the write data is 1, a write to 0x1 clears them, and bits where the data is 0 keep their value. The mask reads back at 0x2.
- R3: A pin whose mode bit is 0 sets its pending bit on both rising and falling changes. A change is found by comparing the input with its value registered on the previous clock, and the pending bit can be read in the cycle after the clock edge that sees the change.
- R4: Writes to 0x3 set and writes to 0x4 clear the per-pin mode bits (write-one). The mode bits read back at 0x5. Clearing a pin's mode bit puts it back in any-edge detection.
- R5: Writes to 0x6 select edge detection and writes to 0x7 select level detection, both write-one. The selection reads back at 0x8, where 1 means level. Writes to 0x9 select falling/low and writes to 0xA select rising/high, both write-one. The polarity reads back at 0xB, where 1 means rising/high.
- R6: With the mode bit set and edge selected, a pin flags only a rising edge if its polarity bit is 1 and only a falling edge if its polarity bit is 0.
- R7: With the mode bit set and level selected, a pin sets its pending bit on every clock where the input equals its polarity bit. This includes the clock on which the status is read, so the bit survives the read for as long as the level holds.
- R8: A read strobe at address 0xC returns the pending bits and clears them on that clock. An event found on the same clock is kept pending. Pending bits are not cleared in any other way.
- R9: Pending bits are recorded whether or not the pin is masked.
- R10: `irq_o` is high exactly when some pending bit is set and has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NPINS | Filtered pin levels |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_re_i | input | 1 | Read strobe, one cycle per read |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | NPINS | Write data, one bit per pin |
| bus_rdata_o | output | NPINS | Read data for the addressed register, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that mask set and clear writes take effect, that a change on a pin in any-edge mode is never missed, that a status read removes every bit except those re-raised on the same clock, that pending bits are held when no read happens, and that the line stays low while the mask is empty. Polarity-specific edges, the re-assertion of a level across reads, an edge landing on the same clock as a read, and the return to any-edge mode after the mode bit is cleared are shown only by the bench's directed scenarios. In those scenarios, and in a random phase, a behavioural model is compared against the outputs on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_MASK_SET  = 4'h0,
    REG_MASK_CLR  = 4'h1,
    REG_MASK      = 4'h2,
    REG_MODE_ON   = 4'h3,
    REG_MODE_OFF  = 4'h4,
    REG_MODE      = 4'h5,
    REG_SEL_EDGE  = 4'h6,
    REG_SEL_LEVEL = 4'h7,
    REG_KIND      = 4'h8,
    REG_POL_LOW   = 4'h9,
    REG_POL_HIGH  = 4'hA,
    REG_POL       = 4'hB,
    REG_STATUS    = 4'hC
  } reg_addr_e;

  // index of each set/clear configuration register
  localparam int unsigned CFG_MASK = 0;
  localparam int unsigned CFG_MODE = 1;
  localparam int unsigned CFG_KIND = 2;
  localparam int unsigned CFG_POL  = 3;
  localparam int unsigned NCFG     = 4;
endpackage

// File: rtl/gpio_irq_setclr.sv
module gpio_irq_setclr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~clr_i) | set_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0] kind_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] prev_o,
  output logic [NPINS-1:0] event_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  assign prev_o = prev_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic rise, fall, hit;
    assign rise = pins_i[p] & ~prev_q[p];
    assign fall = ~pins_i[p] & prev_q[p];

    always_comb begin
      if (!mode_i[p])     hit = rise | fall;
      else if (kind_i[p]) hit = (pins_i[p] == pol_i[p]);
      else                hit = pol_i[p] ? rise : fall;
    end

    assign event_o[p] = hit;
  end
endmodule

// File: rtl/gpio_irq_pending.sv
module gpio_irq_pending #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] event_i,
  input  logic             clear_i,
  output logic [NPINS-1:0] pend_o
);
  logic [NPINS-1:0] pend_q;

  // a same-cycle event wins over the read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (clear_i ? '0 : pend_q) | event_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] wr_data;
  logic [NPINS-1:0] cfg_set [NCFG];
  logic [NPINS-1:0] cfg_clr [NCFG];
  logic [NPINS-1:0] cfg_q   [NCFG];
  logic [NPINS-1:0] mask_q, mode_q, kind_q, pol_q;
  logic [NPINS-1:0] prev_q, event_w, pend_q;
  logic             status_rd;

  assign wr_data = bus_we_i ? bus_wdata_i : '0;

  always_comb begin
    cfg_set[CFG_MASK] = (bus_addr_i == REG_MASK_SET)  ? wr_data : '0;
    cfg_clr[CFG_MASK] = (bus_addr_i == REG_MASK_CLR)  ? wr_data : '0;
    cfg_set[CFG_MODE] = (bus_addr_i == REG_MODE_ON)   ? wr_data : '0;
    cfg_clr[CFG_MODE] = (bus_addr_i == REG_MODE_OFF)  ? wr_data : '0;
    cfg_set[CFG_KIND] = (bus_addr_i == REG_SEL_LEVEL) ? wr_data : '0;
    cfg_clr[CFG_KIND] = (bus_addr_i == REG_SEL_EDGE)  ? wr_data : '0;
    cfg_set[CFG_POL]  = (bus_addr_i == REG_POL_HIGH)  ? wr_data : '0;
    cfg_clr[CFG_POL]  = (bus_addr_i == REG_POL_LOW)   ? wr_data : '0;
  end

  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    gpio_irq_setclr #(.W(NPINS)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (cfg_set[c]),
      .clr_i  (cfg_clr[c]),
      .q_o    (cfg_q[c])
    );
  end

  assign mask_q = cfg_q[CFG_MASK];
  assign mode_q = cfg_q[CFG_MODE];
  assign kind_q = cfg_q[CFG_KIND];
  assign pol_q  = cfg_q[CFG_POL];

  gpio_irq_trigger #(.NPINS(NPINS)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  (pins_i),
    .mode_i  (mode_q),
    .kind_i  (kind_q),
    .pol_i   (pol_q),
    .prev_o  (prev_q),
    .event_o (event_w)
  );

  assign status_rd = bus_re_i && (bus_addr_i == REG_STATUS);

  gpio_irq_pending #(.NPINS(NPINS)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (event_w),
    .clear_i (status_rd),
    .pend_o  (pend_q)
  );

  always_comb begin
    case (bus_addr_i)
      REG_MASK:   bus_rdata_o = mask_q;
      REG_MODE:   bus_rdata_o = mode_q;
      REG_KIND:   bus_rdata_o = kind_q;
      REG_POL:    bus_rdata_o = pol_q;
      REG_STATUS: bus_rdata_o = pend_q;
      default:    bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |(pend_q & mask_q);
endmodule

// File: rtl/gpio_irq_detect_sva.sv
module gpio_irq_detect_sva
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NPINS-1:0]  pins_i,
  input logic              bus_we_i,
  input logic              bus_re_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NPINS-1:0]  bus_wdata_i,
  input logic              irq_o,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  prev_q,
  input logic [NPINS-1:0]  event_w,
  input logic [NPINS-1:0]  pend_q
);
  logic rd_stat;
  assign rd_stat = bus_re_i && (bus_addr_i == REG_STATUS);

  a_r2_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_MASK_SET)
      |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  a_r2_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_MASK_CLR)
      |=> ((mask_q & $past(bus_wdata_i)) == '0));

  a_r3_any_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pins_i) ^ $past(prev_q)) & ~$past(mode_q) & ~pend_q) == '0));

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> ((pend_q & ~$past(event_w)) == '0));

  a_r8_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  a_r10_quiet_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

bind gpio_irq_detect gpio_irq_detect_sva #(.NPINS(NPINS)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pins_i      (pins_i),
  .bus_we_i    (bus_we_i),
  .bus_re_i    (bus_re_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .mask_q      (mask_q),
  .mode_q      (mode_q),
  .prev_q      (prev_q),
  .event_w     (event_w),
  .pend_q      (pend_q)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  localparam int N = 32;
  localparam logic [3:0] A_MSET = 4'h0, A_MCLR = 4'h1, A_MASK = 4'h2,
                         A_MON = 4'h3, A_MOFF = 4'h4, A_MODE = 4'h5,
                         A_EDGE = 4'h6, A_LEVEL = 4'h7, A_KIND = 4'h8,
                         A_PLOW = 4'h9, A_PHIGH = 4'hA, A_POL = 4'hB,
                         A_STAT = 4'hC;

  logic clk_i = 0;
  logic rst_ni = 0;
  logic [N-1:0] pins = '0;
  logic we = 0, re = 0;
  logic [3:0] addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic irq;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  gpio_irq_detect #(.NPINS(N)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [N-1:0] m_mask, m_mode, m_kind, m_pol, m_pend, m_last;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask = '0; m_mode = '0; m_kind = '0; m_pol = '0; m_pend = '0; m_last = '0;
    end else begin
      logic [N-1:0] hits;
      for (int i = 0; i < N; i++) begin
        bit now_v, was_v;
        now_v = pins[i];
        was_v = m_last[i];
        if (m_mode[i] == 0)      hits[i] = (now_v != was_v);
        else if (m_kind[i] == 1) hits[i] = (now_v == m_pol[i]);
        else                     hits[i] = (now_v != was_v) && (now_v == m_pol[i]);
      end
      if (re && addr == A_STAT) m_pend = '0;
      m_pend = m_pend | hits;
      m_last = pins;
      if (we) begin
        case (addr)
          A_MSET:  m_mask = m_mask | wdata;
          A_MCLR:  m_mask = m_mask & ~wdata;
          A_MON:   m_mode = m_mode | wdata;
          A_MOFF:  m_mode = m_mode & ~wdata;
          A_LEVEL: m_kind = m_kind | wdata;
          A_EDGE:  m_kind = m_kind & ~wdata;
          A_PHIGH: m_pol  = m_pol | wdata;
          A_PLOW:  m_pol  = m_pol & ~wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [N-1:0] m_read(logic [3:0] a);
    case (a)
      A_MASK: return m_mask;
      A_MODE: return m_mode;
      A_KIND: return m_kind;
      A_POL:  return m_pol;
      A_STAT: return m_pend;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      chk("R10 model irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_pend & m_mask)});
      chk("R2/R4/R5/R8 model rdata", rdata, m_read(addr));
    end
  end

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk_i);
    we = 1; re = 0; addr = a; wdata = d;
    @(negedge clk_i);
    we = 0; wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [N-1:0] v);
    @(negedge clk_i);
    re = 1; we = 0; addr = a;
    #1 v = rdata;
    @(negedge clk_i);
    re = 0;
  endtask

  task automatic set_pins(logic [N-1:0] v);
    @(negedge clk_i);
    pins = v;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, errs);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;

    // R1 reset state
    @(negedge clk_i); #1 chk("R1 irq", {{(N-1){1'b0}}, irq}, '0);
    rd_chk("R1 mask", A_MASK, '0);
    rd_chk("R1 mode", A_MODE, '0);
    rd_chk("R1 kind", A_KIND, '0);
    rd_chk("R1 pol", A_POL, '0);
    rd_chk("R1 status", A_STAT, '0);

    // R2 write-one mask
    wr(A_MSET, 32'h0000_00F0);
    wr(A_MCLR, 32'h0000_0030);
    rd_chk("R2 mask", A_MASK, 32'h0000_00C0);
    wr(A_MCLR, '1);
    wr(A_MSET, 32'h1);
    rd_chk("R2 mask one", A_MASK, 32'h1);

    // R3 any edge, R10 irq, R8 clear on read
    set_pins(32'h1);
    @(negedge clk_i); #1 chk("R10 irq up", {{(N-1){1'b0}}, irq}, 32'h1);
    rd_chk("R3 rise", A_STAT, 32'h1);
    rd_chk("R8 cleared", A_STAT, '0);
    @(negedge clk_i); #1 chk("R10 irq down", {{(N-1){1'b0}}, irq}, '0);
    set_pins(32'h0);
    rd_chk("R3 fall", A_STAT, 32'h1);
    rd_chk("R8 cleared again", A_STAT, '0);

    // R9 masked pin still pends
    set_pins(32'h100);
    @(negedge clk_i); #1 chk("R9 no irq", {{(N-1){1'b0}}, irq}, '0);
    rd_chk("R9 pend masked", A_STAT, 32'h100);
    set_pins(32'h0);
    rd_chk("R9 pend masked fall", A_STAT, 32'h100);

    // R4 mode register
    wr(A_MON, 32'h3);
    wr(A_MOFF, 32'h1);
    rd_chk("R4 mode", A_MODE, 32'h2);

    // R6 rising only on pin1
    wr(A_EDGE, 32'h2);
    wr(A_PHIGH, 32'h2);
    set_pins(32'h2);
    rd_chk("R6 rising seen", A_STAT, 32'h2);
    set_pins(32'h0);
    rd_chk("R6 falling ignored", A_STAT, '0);

    // R6 falling only on pin3
    wr(A_PLOW, 32'h8);
    wr(A_MON, 32'h8);
    set_pins(32'h8);
    rd_chk("R6 rising ignored", A_STAT, '0);
    set_pins(32'h0);
    rd_chk("R6 falling seen", A_STAT, 32'h8);

    // R7 level high on pin2
    wr(A_LEVEL, 32'h4);
    wr(A_PHIGH, 32'h4);
    wr(A_MON, 32'h4);
    rd_chk("R7 idle", A_STAT, '0);
    set_pins(32'h4);
    rd_chk("R7 level high", A_STAT, 32'h4);
    rd_chk("R7 survives read", A_STAT, 32'h4);
    set_pins(32'h0);
    rd_chk("R7 held after release", A_STAT, 32'h4);
    rd_chk("R7 gone", A_STAT, '0);

    // R7 level low on pin4
    wr(A_LEVEL, 32'h10);
    wr(A_MON, 32'h10);
    rd_chk("R7 level low", A_STAT, 32'h10);
    set_pins(32'h10);
    rd_chk("R7 low held", A_STAT, 32'h10);
    rd_chk("R7 low gone", A_STAT, '0);

    // R8 edge on the read clock is kept
    @(negedge clk_i);
    pins = pins | 32'h20; re = 1; addr = A_STAT;
    #1 v = rdata;
    chk("R8 read before edge", v, '0);
    @(negedge clk_i); re = 0;
    rd_chk("R8 edge kept", A_STAT, 32'h20);

    // R4 clearing mode restores any edge
    wr(A_MOFF, 32'h2);
    set_pins(pins | 32'h2);
    rd_chk("R4 any edge rise", A_STAT, 32'h2);
    set_pins(pins & ~32'h2);
    rd_chk("R4 any edge fall", A_STAT, 32'h2);

    // R5 readback
    rd_chk("R5 kind", A_KIND, 32'h14);
    rd_chk("R5 pol", A_POL, 32'h6);
    rd_chk("R4 mode after", A_MODE, 32'h1C);

    // R10 level source unmasked
    wr(A_MSET, 32'h4);
    set_pins(pins | 32'h4);
    @(negedge clk_i); #1 chk("R10 level irq", {{(N-1){1'b0}}, irq}, 32'h1);

    // random phase against the model
    for (int k = 0; k < 600; k++) begin
      int op;
      @(negedge clk_i);
      op = $urandom_range(0, 9);
      pins = $urandom;
      we = 0; re = 0;
      if (op < 2) begin
        we = 1; addr = 4'($urandom_range(0, 11)); wdata = $urandom;
      end else if (op < 5) begin
        re = 1; addr = A_STAT;
      end else begin
        addr = 4'($urandom_range(0, 12));
      end
    end
    @(negedge clk_i); we = 0; re = 0;
    @(negedge clk_i);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, errs);
    $finish;
  end
endmodule